// File: doc/BRIEF.md
# Counted Pulse and Transition Burst Generator

This block drives one output pin with a finite burst of activity and then stops by itself. Software first sets up a 32-bit configuration word and a mode select. Writing a count then starts a burst that lasts for exactly that many pulses or edges. When the burst is over, the output drops low, the output-enable goes inactive and a sticky done flag goes high. The flag stays set until the next count write or an acknowledge.

In pulse mode the low half of the configuration word is the length of each pulse period in system clocks. The high half is a compare value: the output is high while the position inside the period is below it. In transition mode the low half is a prescaler. The output toggles once per prescaler interval, and the count is the number of transitions, so a count of ten gives five full pulses. A field of zero means 65536 clocks, so the slowest rate is the system clock divided by 2^16.

Top module: `burst_pin_gen`

## Requirements
- R1: In pulse mode (modeSel = 0), with P = cfgWord[15:0] and C = cfgWord[31:16], pinOut during burst cycle t (t = 0 is the first cycle after the count write edge) is high exactly when (t mod P) < C. C = 0 gives a burst that is low throughout, and C >= P gives one that is high throughout.
- R2: In pulse mode a count N > 0 keeps the burst running for exactly N*P cycles, with pinOe high on every one of them.
- R3: In transition mode (modeSel = 1), with Q = cfgWord[15:0], pinOut is low for the first Q cycles and toggles after every Q cycles. The burst lasts N*Q cycles for a count N, so N = 10 gives 5 high pulses.
- R4: A period or prescaler field of 0 is treated as 65536 clocks.
- R5: Writing a count of 0 starts no burst. pinOut and pinOe stay low, and doneFlag is high from the next cycle.
- R6: A count write during a burst drops the current burst and starts a new one from cycle 0, with the new count, configuration and mode. It also clears doneFlag.
- R7: doneFlag goes high in the cycle after a burst's last cycle. It stays high until a count write or an ack clears it. A burst end in the same cycle as ack leaves it set.
- R8: Outside a burst, including after reset, pinOut and pinOe are low. After reset doneFlag is low.
- R9: modeSel and cfgWord are captured at the count write. Changing them during a burst has no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 1 | 0 = pulse mode, 1 = transition mode |
| cfgWord | input | 32 | [15:0] period or prescaler, [31:16] pulse compare |
| countVal | input | 32 | Number of pulses (pulse mode) or transitions (transition mode) |
| countWr | input | 1 | Write strobe for countVal; starts or restarts a burst |
| ack | input | 1 | Clears doneFlag |
| pinOut | output | 1 | Pin output level |
| pinOe | output | 1 | Pin output-enable, high during a burst |
| doneFlag | output | 1 | Sticky burst-complete flag |

## Verification
Pulse mode is tried with a compare below the period, with a compare of zero and with a compare above the period. These cases separate a correct less-than test from an off-by-one or inverted comparison. Transition mode is tried with a prescaler of one, a prescaler of two and three, and odd and even counts, so that a wrong toggle phase or a wrong interval length shows up. A zero period field with the compare at half of 65536 shows whether zero is widened to the full range. Directed runs check restarting mid-burst, zero counts and input changes during a burst, and show whether configuration is taken live instead of latched.

// File: rtl/burst_pkg.sv
package burst_pkg;

  typedef enum logic {
    MODE_PULSE  = 1'b0,
    MODE_TOGGLE = 1'b1
  } burst_mode_e;

  // strobes from the control to the datapath
  typedef struct packed {
    logic load;  // capture settings and start from cycle 0
    logic run;   // burst in progress, advance counters
  } burst_strobe_t;

endpackage

// File: rtl/burst_datapath.sv
module burst_datapath
  import burst_pkg::*;
#(
  parameter int PERIOD_W = 16,
  parameter int COUNT_W  = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  burst_strobe_t         strobe,
  input  logic                  modeIn,
  input  logic [2*PERIOD_W-1:0] cfgIn,
  input  logic [COUNT_W-1:0]    countIn,
  output logic                  intervalEnd,
  output logic                  lastInterval,
  output logic                  pinLevel
);

  localparam int PH_W = PERIOD_W + 1;
  localparam logic [PH_W-1:0] FULL_LEN = PH_W'(1) << PERIOD_W;

  burst_mode_e          modeQ;
  logic [PERIOD_W-1:0]  lenField;
  logic [PERIOD_W-1:0]  cmpField;
  logic [PH_W-1:0]      phase;
  logic [PH_W-1:0]      lenFull;
  logic [COUNT_W-1:0]   remaining;
  logic                 togQ;
  logic                 pulseHigh;

  // a zero field stands for the full 2^PERIOD_W range
  always_comb begin
    if (lenField == '0) lenFull = FULL_LEN;
    else                lenFull = {1'b0, lenField};
  end

  assign intervalEnd  = (phase == lenFull - PH_W'(1));
  assign lastInterval = (remaining == COUNT_W'(1));
  assign pulseHigh    = (phase < {1'b0, cmpField});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ     <= MODE_PULSE;
      lenField  <= '0;
      cmpField  <= '0;
      phase     <= '0;
      remaining <= '0;
      togQ      <= 1'b0;
    end else if (strobe.load) begin
      modeQ     <= burst_mode_e'(modeIn);
      lenField  <= cfgIn[PERIOD_W-1:0];
      cmpField  <= cfgIn[2*PERIOD_W-1:PERIOD_W];
      phase     <= '0;
      remaining <= countIn;
      togQ      <= 1'b0;
    end else if (strobe.run) begin
      if (intervalEnd) begin
        phase     <= '0;
        remaining <= remaining - COUNT_W'(1);
        togQ      <= ~togQ;
      end else begin
        phase <= phase + PH_W'(1);
      end
    end
  end

  always_comb begin
    pinLevel = 1'b0;
    if (strobe.run) begin
      if (modeQ == MODE_PULSE) pinLevel = pulseHigh;
      else                     pinLevel = togQ;
    end
  end

endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
#(
  parameter int COUNT_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               countWr,
  input  logic [COUNT_W-1:0] countIn,
  input  logic               ack,
  input  logic               intervalEnd,
  input  logic               lastInterval,
  output burst_strobe_t      strobe,
  output logic               doneFlag
);

  typedef enum logic {ST_IDLE, ST_RUN} state_e;

  state_e stateQ;
  state_e stateD;
  logic   countZero;
  logic   finish;
  logic   doneD;

  assign countZero = (countIn == '0);
  assign finish    = (stateQ == ST_RUN) && intervalEnd && lastInterval;

  always_comb begin
    stateD = stateQ;
    if (countWr)     stateD = countZero ? ST_IDLE : ST_RUN;
    else if (finish) stateD = ST_IDLE;
  end

  always_comb begin
    doneD = doneFlag;
    if (countWr)     doneD = countZero;
    else if (finish) doneD = 1'b1;
    else if (ack)    doneD = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      doneFlag <= 1'b0;
    end else begin
      stateQ   <= stateD;
      doneFlag <= doneD;
    end
  end

  always_comb begin
    strobe.load = countWr && !countZero;
    strobe.run  = (stateQ == ST_RUN);
  end

endmodule

// File: rtl/burst_pin_gen.sv
module burst_pin_gen
  import burst_pkg::*;
#(
  parameter int PERIOD_W = 16,
  parameter int COUNT_W  = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  modeSel,
  input  logic [2*PERIOD_W-1:0] cfgWord,
  input  logic [COUNT_W-1:0]    countVal,
  input  logic                  countWr,
  input  logic                  ack,
  output logic                  pinOut,
  output logic                  pinOe,
  output logic                  doneFlag
);

  burst_strobe_t strobe;
  logic intervalEnd;
  logic lastInterval;

  burst_ctrl #(.COUNT_W(COUNT_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .countWr     (countWr),
    .countIn     (countVal),
    .ack         (ack),
    .intervalEnd (intervalEnd),
    .lastInterval(lastInterval),
    .strobe      (strobe),
    .doneFlag    (doneFlag)
  );

  burst_datapath #(.PERIOD_W(PERIOD_W), .COUNT_W(COUNT_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .modeIn      (modeSel),
    .cfgIn       (cfgWord),
    .countIn     (countVal),
    .intervalEnd (intervalEnd),
    .lastInterval(lastInterval),
    .pinLevel    (pinOut)
  );

  assign pinOe = strobe.run;

endmodule

// File: rtl/burst_checker.sv
module burst_checker #(
  parameter int PERIOD_W = 16,
  parameter int COUNT_W  = 32
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  modeSel,
  input logic [2*PERIOD_W-1:0] cfgWord,
  input logic [COUNT_W-1:0]    countVal,
  input logic                  countWr,
  input logic                  ack,
  input logic                  pinOut,
  input logic                  pinOe,
  input logic                  doneFlag
);

  // R8: no drive outside a burst
  p_idle_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    !pinOe |-> !pinOut);

  // R5: zero count finishes at once without activity
  p_zero_count_r5: assert property (@(posedge clk) disable iff (!rstN)
    (countWr && countVal == '0) |=> (doneFlag && !pinOe));

  // R6: a nonzero count write starts a burst and clears done
  p_restart_r6: assert property (@(posedge clk) disable iff (!rstN)
    (countWr && countVal != '0) |=> (pinOe && !doneFlag));

  // R3: transition bursts begin low
  p_toggle_start_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    (countWr && countVal != '0 && modeSel) |=> !pinOut);

  // R7: done holds without a clearing event
  p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && !countWr && !ack) |=> doneFlag);

  // R7: ack clears done when no burst is ending
  p_ack_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ack && !countWr && !pinOe) |=> !doneFlag);

  // R7: a burst that ends by itself raises done
  p_end_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pinOe && !countWr) |=> (pinOe || doneFlag));

endmodule

bind burst_pin_gen burst_checker #(.PERIOD_W(PERIOD_W), .COUNT_W(COUNT_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .modeSel (modeSel),
  .cfgWord (cfgWord),
  .countVal(countVal),
  .countWr (countWr),
  .ack     (ack),
  .pinOut  (pinOut),
  .pinOe   (pinOe),
  .doneFlag(doneFlag)
);

// File: tb/sim_burst_pin_gen.sv
module sim_burst_pin_gen;

  localparam int CLK_NS = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modeSel = 1'b0;
  logic [31:0] cfgWord = '0;
  logic [31:0] countVal = '0;
  logic        countWr = 1'b0;
  logic        ack = 1'b0;
  logic        pinOut;
  logic        pinOe;
  logic        doneFlag;

  int checks = 0;
  int fails = 0;

  always #(CLK_NS/2) clk = ~clk;

  burst_pin_gen u0 (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .cfgWord(cfgWord),
    .countVal(countVal), .countWr(countWr), .ack(ack),
    .pinOut(pinOut), .pinOe(pinOe), .doneFlag(doneFlag)
  );

  // {mode, cfg, count}
  localparam logic [64:0] VEC [7] = '{
    {1'b0, 16'd2,  16'd4, 32'd3},   // R1 compare below period
    {1'b0, 16'd1,  16'd5, 32'd2},   // R1 short high part
    {1'b0, 16'd5,  16'd3, 32'd2},   // R1 compare above period
    {1'b0, 16'd0,  16'd4, 32'd2},   // R1 compare zero
    {1'b1, 16'd0,  16'd3, 32'd4},   // R3 prescaler 3
    {1'b1, 16'd0,  16'd1, 32'd10},  // R3 ten edges, five pulses
    {1'b1, 16'd0,  16'd2, 32'd3}    // R3 odd count
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit expLevel(input bit mode, input logic [31:0] cfg, input int t);
    int len = (cfg[15:0] == 16'd0) ? 65536 : int'(cfg[15:0]);
    if (!mode) return (t % len) < int'(cfg[31:16]);
    return ((t / len) % 2) == 1;
  endfunction

  // Called at a negedge; writes the count, then follows the whole burst.
  // disturb: change mode and cfg at cycle 2 (R9). stopAt: leave early.
  task automatic runBurst(input bit mode, input logic [31:0] cfg, input int n,
                          input string tag, input bit disturb, input int stopAt);
    int len = (cfg[15:0] == 16'd0) ? 65536 : int'(cfg[15:0]);
    int dur = n * len;
    int bad = 0;
    int badT = -1;
    int badAct = 0;
    modeSel = mode; cfgWord = cfg; countVal = n; countWr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    countWr = 1'b0;
    check(pinOe === 1'b1 && doneFlag === 1'b0, {tag, " start oe/done"},
          int'({pinOe, doneFlag}), 2);
    for (int t = 0; t < dur; t++) begin
      if (t == stopAt) return;
      if (disturb && t == 2) begin modeSel = ~mode; cfgWord = 32'h0001_0007; end
      if (pinOut !== expLevel(mode, cfg, t) || pinOe !== 1'b1) begin
        if (bad == 0) begin badT = t; badAct = int'(pinOut); end
        bad++;
      end
      @(negedge clk);
    end
    check(bad == 0, {tag, " waveform"}, badT, badAct ^ 1);
    check(pinOe === 1'b0 && pinOut === 1'b0 && doneFlag === 1'b1,
          {tag, " end state R2 R7 R8"}, int'({pinOe, pinOut, doneFlag}), 1);
  endtask

  initial begin
    #(CLK_NS * 200000);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    check(pinOut === 1'b0 && pinOe === 1'b0 && doneFlag === 1'b0, "R8 reset",
          int'({pinOut, pinOe, doneFlag}), 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 7; i++) begin
      runBurst(VEC[i][64], VEC[i][63:32], int'(VEC[i][31:0]),
               $sformatf("R1 R2 R3 vec%0d", i), 1'b0, -1);
      @(negedge clk);
    end

    // R7 done sticky, then ack clears it
    repeat (4) @(negedge clk);
    check(doneFlag === 1'b1, "R7 sticky", int'(doneFlag), 1);
    ack = 1'b1; @(negedge clk); ack = 1'b0;
    check(doneFlag === 1'b0, "R7 ack clear", int'(doneFlag), 0);

    // R5 zero count
    modeSel = 1'b0; cfgWord = 32'h0002_0004; countVal = 0; countWr = 1'b1;
    @(negedge clk); countWr = 1'b0;
    check(doneFlag === 1'b1 && pinOe === 1'b0 && pinOut === 1'b0, "R5 zero count",
          int'({doneFlag, pinOe, pinOut}), 4);
    repeat (3) @(negedge clk);
    check(pinOe === 1'b0 && pinOut === 1'b0, "R5 still idle", int'({pinOe, pinOut}), 0);

    // R6 retrigger mid-burst with new mode and count
    runBurst(1'b0, 32'h0005_000A, 5, "R6 first", 1'b0, 7);
    runBurst(1'b1, 32'h0000_0002, 4, "R6 restart", 1'b0, -1);

    // R9 live input changes ignored
    runBurst(1'b0, 32'h0001_0004, 3, "R9 latched", 1'b1, -1);
    runBurst(1'b1, 32'h0000_0003, 4, "R9 latched toggle", 1'b1, -1);

    // R4 zero period means 65536, half-duty
    runBurst(1'b0, 32'h8000_0000, 1, "R4 full period", 1'b0, -1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule